// File: doc/BRIEF.md
# Translation Entry Staging Port

This block keeps a small set of address translation entries split across two arrays. Each array has a fixed number of ways. Software does not reach the entries directly. It loads five 32-bit staging words through a plain register interface, then issues a write command. The block packs those words into the entry named by the array and way fields of the select word. A read command does the reverse: it unpacks the named entry back into the five staging words, where software can read them.

An entry holds the following fields:
- an effective page number
- a 52-bit real page number
- an 8-bit process tag
- the page size, kept as a byte count that is always 1024 × 4^code
- an address-space bit
- seven memory attribute bits
- an invalidation-protect flag
- six access permissions: read, write and execute, each for user and for supervisor

Each array has its own configuration. The configuration decides whether the requested size code is honoured or replaced by the array's minimum code. It also decides whether the protect flag may be stored. A two-bit qualifier in the select word decides whether a write command is committed or dropped. A next-victim counter advances on every committed write, and a read reports its value.

Top module: `xlat_entry_port`

## Requirements
- R1: After reset, all five staging words read 0, `busy` and `done` are 0, and every entry reads back as an all-zero entry with size code 0.
- R2: Register indices 0 to 4 select the select, tag, page, real-low and real-high staging words. When the block is idle, `reg_we` stores `reg_wdata` into the indexed word. `reg_rdata` returns the stored word combinationally. Indices 5 to 7 read 0, and writes to them have no effect.
- R3: The size code sits in tag bits [11:8]. When the array's variable-size flag is set, the requested code is stored. Otherwise the array's minimum code is stored. A read returns the code rebuilt from the stored byte size 1024 × 4^code. The defaults are: array 0 is variable, array 1 is fixed with minimum code 2.
- R4: The real page number is the real-high word (upper 32 bits) joined with real-low bits [31:12]. Real-low bits [11:6] are not stored and read back as 0.
- R5: Select bits [1:0] form the qualifier. Only value 0 commits a write. Values 1, 2 and 3 leave the entry and the next-victim counter unchanged.
- R6: Real-low bits [5:0] are stored as six separate permissions: user read, user write, user execute, supervisor read, supervisor write, supervisor execute. They read back unchanged.
- R7: Tag bit 30 (protect) is stored only when the array's protect flag is set (by default only array 1). Tag bit 12 (address space), tag bits [23:16] (process tag), page-word bits [31:12] (page number) and page-word bits [6:0] (attributes) are stored as given. All other tag and page-word bits read back as 0.
- R8: A read sets tag bit 31 to 1 whatever was written. It also loads the select word with the array in bit 4, the way in bits [11:8], the next-victim counter in bits [19:16], and 0 in every other bit.
- R9: The next-victim counter starts at 0, advances by one on each committed write, and wraps modulo the way count (default 4).
- R10: A command raises `busy` for exactly one cycle after the edge that accepts it. `done` pulses in the following cycle, and the staging words of a read are updated on that same edge. Commands and register writes that arrive while `busy` is high are ignored.
- R11: The select word's array bit and way field address a distinct entry. A write changes no other entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Staging word write strobe |
| reg_addr | input | 3 | Staging word index |
| reg_wdata | input | 32 | Staging word write data |
| reg_rdata | output | 32 | Staging word read data |
| cmd_write | input | 1 | Pack staging words into the selected entry |
| cmd_read | input | 1 | Unpack the selected entry into the staging words |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command finishes |

## Verification
The assertions rely on software keeping the way field below the way count, so that every access reaches a real entry. The size checks rely on every stored size coming from a 4-bit code, because that is what makes the stored byte count a single set bit at or above 1024. The stimulus uses only ways 0 to 3. It drives commands as one-cycle pulses and never raises both command inputs together. The only exception is a deliberate read request placed inside a busy cycle, which the block must ignore.

// File: rtl/xep_pkg.sv
package xep_pkg;
  localparam int EPN_W     = 20;
  localparam int RLO_W     = 20;
  localparam int RHI_W     = 32;
  localparam int RPN_W     = RLO_W + RHI_W;
  localparam int PID_W     = 8;
  localparam int TSZ_W     = 4;
  localparam int ATTR_W    = 7;
  localparam int PERM_W    = 6;
  localparam int MIN_SHIFT = 10;
  localparam int BYTES_W   = MIN_SHIFT + 2 * ((1 << TSZ_W) - 1) + 1;

  // staging word field positions
  localparam int SEL_ARR_BIT = 4;
  localparam int SEL_WAY_LSB = 8;
  localparam int SEL_NV_LSB  = 16;
  localparam int TAG_VALID   = 31;
  localparam int TAG_PROT    = 30;
  localparam int TAG_PID_LSB = 16;
  localparam int TAG_TS      = 12;
  localparam int TAG_TSZ_LSB = 8;

  localparam logic [1:0] QUAL_ALWAYS = 2'd0;

  typedef struct packed {
    logic [EPN_W-1:0]   epn;
    logic [RPN_W-1:0]   rpn;
    logic [PID_W-1:0]   pid;
    logic [BYTES_W-1:0] bytes;
    logic               prot;
    logic [ATTR_W-1:0]  attr;
    logic               ts;
    logic [PERM_W-1:0]  perm;
  } entry_t;

  // size code -> byte count: 1024 * 4^code
  function automatic logic [BYTES_W-1:0] tsz_to_bytes(input logic [TSZ_W-1:0] code);
    return BYTES_W'(1) << (MIN_SHIFT + 2 * int'(code));
  endfunction

  // byte count -> size code; zero maps to code 0
  function automatic logic [TSZ_W-1:0] bytes_to_tsz(input logic [BYTES_W-1:0] b);
    logic [TSZ_W-1:0] r;
    r = '0;
    for (int i = 0; i < (1 << TSZ_W); i++) begin
      if (b == tsz_to_bytes(TSZ_W'(i))) r = TSZ_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/xep_pack.sv
module xep_pack
  import xep_pkg::*;
#(
  parameter logic [1:0]       VAR_SIZE = 2'b01,
  parameter logic [1:0]       PROT_OK  = 2'b10,
  parameter logic [TSZ_W-1:0] MIN_TSZ0 = 4'd1,
  parameter logic [TSZ_W-1:0] MIN_TSZ1 = 4'd2
) (
  input  logic              arr,
  input  logic [TSZ_W-1:0]  tsz_req,
  input  logic [PID_W-1:0]  pid,
  input  logic              prot_req,
  input  logic              ts,
  input  logic [EPN_W-1:0]  epn,
  input  logic [ATTR_W-1:0] attr,
  input  logic [RLO_W-1:0]  rpn_lo,
  input  logic [RHI_W-1:0]  rpn_hi,
  input  logic [PERM_W-1:0] perm,
  output entry_t            ent
);
  logic [TSZ_W-1:0] tsz_eff;

  always_comb begin
    if (VAR_SIZE[arr]) tsz_eff = tsz_req;
    else               tsz_eff = arr ? MIN_TSZ1 : MIN_TSZ0;

    ent       = '0;
    ent.epn   = epn;
    ent.rpn   = {rpn_hi, rpn_lo};
    ent.pid   = pid;
    ent.bytes = tsz_to_bytes(tsz_eff);
    ent.prot  = PROT_OK[arr] & prot_req;
    ent.attr  = attr;
    ent.ts    = ts;
    ent.perm  = perm;
  end
endmodule

// File: rtl/xep_unpack.sv
module xep_unpack
  import xep_pkg::*;
#(
  parameter int WAYS_W = 2
) (
  input  entry_t            ent,
  input  logic              arr,
  input  logic [WAYS_W-1:0] way,
  input  logic [WAYS_W-1:0] nv,
  output logic [31:0]       w_sel,
  output logic [31:0]       w_tag,
  output logic [31:0]       w_epn,
  output logic [31:0]       w_lo,
  output logic [31:0]       w_hi
);
  always_comb begin
    w_sel = '0;
    w_sel[SEL_ARR_BIT] = arr;
    w_sel[SEL_WAY_LSB +: WAYS_W] = way;
    w_sel[SEL_NV_LSB  +: WAYS_W] = nv;

    w_tag = '0;
    w_tag[TAG_VALID] = 1'b1;
    w_tag[TAG_PROT]  = ent.prot;
    w_tag[TAG_PID_LSB +: PID_W] = ent.pid;
    w_tag[TAG_TS]    = ent.ts;
    w_tag[TAG_TSZ_LSB +: TSZ_W] = bytes_to_tsz(ent.bytes);

    w_epn = {ent.epn, 5'b0, ent.attr};
    w_lo  = {ent.rpn[RLO_W-1:0], 6'b0, ent.perm};
    w_hi  = ent.rpn[RPN_W-1:RLO_W];
  end
endmodule

// File: rtl/xep_store.sv
module xep_store
  import xep_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAYS_W = $clog2(WAYS),
  localparam int NENT   = 2 * WAYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              arr,
  input  logic [WAYS_W-1:0] way,
  input  entry_t            wdata,
  output entry_t            rdata
);
  entry_t [NENT-1:0] mem;
  logic   [NENT-1:0] hit;
  logic   [WAYS_W:0] idx;

  assign idx = {arr, way};

  for (genvar e = 0; e < NENT; e++) begin : g_hit
    assign hit[e] = we && (idx == (WAYS_W+1)'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (hit[e]) mem[e] <= wdata;
      end
    end
  end

  assign rdata = mem[idx];

  // R5 / R11: without a commit no entry moves
  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

  // R3: a committed size is a single power of four at or above 1 KiB
  a_r3_size_pow4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(wdata.bytes) == 1 && wdata.bytes[MIN_SHIFT-1:0] == '0));
endmodule

// File: rtl/xlat_entry_port.sv
module xlat_entry_port
  import xep_pkg::*;
#(
  parameter int               WAYS     = 4,
  parameter logic [1:0]       VAR_SIZE = 2'b01,
  parameter logic [1:0]       PROT_OK  = 2'b10,
  parameter logic [TSZ_W-1:0] MIN_TSZ0 = 4'd1,
  parameter logic [TSZ_W-1:0] MIN_TSZ1 = 4'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cmd_write,
  input  logic        cmd_read,
  output logic        busy,
  output logic        done
);
  localparam int WAYS_W = $clog2(WAYS);

  logic [31:0] sel_q, tag_q, epn_q, lo_q, hi_q;
  logic        busy_q, done_q, op_rd_q;
  logic [WAYS_W-1:0] nv_q;

  logic              cur_arr;
  logic [WAYS_W-1:0] cur_way;
  logic              commit;
  logic              load_stage;
  entry_t            wr_ent, rd_ent;
  logic [31:0]       u_sel, u_tag, u_epn, u_lo, u_hi;

  assign cur_arr    = sel_q[SEL_ARR_BIT];
  assign cur_way    = sel_q[SEL_WAY_LSB +: WAYS_W];
  assign commit     = busy_q && !op_rd_q && (sel_q[1:0] == QUAL_ALWAYS);
  assign load_stage = busy_q && op_rd_q;

  xep_pack #(
    .VAR_SIZE(VAR_SIZE), .PROT_OK(PROT_OK),
    .MIN_TSZ0(MIN_TSZ0), .MIN_TSZ1(MIN_TSZ1)
  ) u_pack (
    .arr      (cur_arr),
    .tsz_req  (tag_q[TAG_TSZ_LSB +: TSZ_W]),
    .pid      (tag_q[TAG_PID_LSB +: PID_W]),
    .prot_req (tag_q[TAG_PROT]),
    .ts       (tag_q[TAG_TS]),
    .epn      (epn_q[31:12]),
    .attr     (epn_q[ATTR_W-1:0]),
    .rpn_lo   (lo_q[31:12]),
    .rpn_hi   (hi_q),
    .perm     (lo_q[PERM_W-1:0]),
    .ent      (wr_ent)
  );

  xep_store #(.WAYS(WAYS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit),
    .arr   (cur_arr),
    .way   (cur_way),
    .wdata (wr_ent),
    .rdata (rd_ent)
  );

  xep_unpack #(.WAYS_W(WAYS_W)) u_unpack (
    .ent   (rd_ent),
    .arr   (cur_arr),
    .way   (cur_way),
    .nv    (nv_q),
    .w_sel (u_sel),
    .w_tag (u_tag),
    .w_epn (u_epn),
    .w_lo  (u_lo),
    .w_hi  (u_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; tag_q <= '0; epn_q <= '0; lo_q <= '0; hi_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; op_rd_q <= 1'b0; nv_q <= '0;
    end else begin
      done_q <= busy_q;
      if (busy_q) begin
        busy_q <= 1'b0;
        if (load_stage) begin
          sel_q <= u_sel; tag_q <= u_tag; epn_q <= u_epn; lo_q <= u_lo; hi_q <= u_hi;
        end
        if (commit) nv_q <= nv_q + 1'b1;
      end else begin
        if (cmd_write || cmd_read) begin
          busy_q  <= 1'b1;
          op_rd_q <= !cmd_write;
        end
        if (reg_we) begin
          case (reg_addr)
            3'd0: sel_q <= reg_wdata;
            3'd1: tag_q <= reg_wdata;
            3'd2: epn_q <= reg_wdata;
            3'd3: lo_q  <= reg_wdata;
            3'd4: hi_q  <= reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = sel_q;
      3'd1:    reg_rdata = tag_q;
      3'd2:    reg_rdata = epn_q;
      3'd3:    reg_rdata = lo_q;
      3'd4:    reg_rdata = hi_q;
      default: reg_rdata = '0;
    endcase
  end

  assign busy = busy_q;
  assign done = done_q;

  // R10: busy lasts one cycle and is followed by done
  a_r10_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q && done_q));
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
  // R8: a finished read leaves the valid bit set in the tag word
  a_r8_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_rd_q) |-> tag_q[TAG_VALID]);
  // R9: the victim counter moves only on a committed write
  a_r9_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(nv_q));
endmodule

// File: tb/xlat_entry_port_tb.sv
`timescale 1ns/1ps
module xlat_entry_port_tb;
  typedef struct packed {
    logic        arr;
    logic [1:0]  way;
    logic [1:0]  qual;
    logic [31:0] tag;
    logic [31:0] epn;
    logic [31:0] lo;
    logic [31:0] hi;
  } vec_t;

  // array configuration as stated in R3 / R7
  localparam logic [1:0] VARSZ  = 2'b01;
  localparam logic [1:0] PROTOK = 2'b10;
  localparam logic [3:0] MIN0   = 4'd1;
  localparam logic [3:0] MIN1   = 4'd2;
  localparam int NV = 9;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 2'd0, 32'h40AB_0523, 32'h1234_5FFF, 32'hABCD_EFFF, 32'hDEAD_BEEF},
    '{1'b0, 2'd3, 2'd0, 32'h0012_1F00, 32'hFFFF_F055, 32'h0000_1015, 32'h0000_0000},
    '{1'b1, 2'd1, 2'd0, 32'hC055_0700, 32'h0000_1001, 32'h1111_102A, 32'h0000_0001},
    '{1'b1, 2'd1, 2'd1, 32'h00FF_0300, 32'h7777_7000, 32'h5555_5000, 32'h0000_0002},
    '{1'b0, 2'd0, 2'd2, 32'h0033_0200, 32'h0000_0000, 32'h0000_0000, 32'h0000_0003},
    '{1'b0, 2'd0, 2'd3, 32'h0044_0100, 32'h0000_0000, 32'h0000_0000, 32'h0000_0004},
    '{1'b1, 2'd2, 2'd0, 32'h8000_0000, 32'h0000_0000, 32'h0000_0009, 32'h8000_0000},
    '{1'b0, 2'd2, 2'd0, 32'h00FE_1000, 32'hABCD_E000, 32'h0000_0020, 32'h7FFF_FFFF},
    '{1'b0, 2'd1, 2'd0, 32'h0001_0100, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, cmd_write = 1'b0, cmd_read = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic busy, done;

  int nchk = 0, nfail = 0;
  int nv_exp = 0;
  logic [31:0] sh_tag [8], sh_epn [8], sh_lo [8], sh_hi [8];

  always #2.5 clk = ~clk;

  xlat_entry_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_write(cmd_write),
    .cmd_read(cmd_read), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_cmd(input bit rd);
    @(negedge clk);
    cmd_write = !rd; cmd_read = rd;
    @(negedge clk);
    cmd_write = 1'b0; cmd_read = 1'b0;
    chk("R10 busy", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk("R10 done", {30'b0, busy, done}, 32'd1);
  endtask

  // expected readback words of a committed write (R3, R4, R6, R7)
  task automatic expect_of(input vec_t v);
    logic [3:0] tsz;
    logic       p;
    int         e;
    e   = int'(v.arr) * 4 + int'(v.way);
    tsz = VARSZ[v.arr] ? v.tag[11:8] : (v.arr ? MIN1 : MIN0);
    p   = PROTOK[v.arr] & v.tag[30];
    sh_tag[e] = {1'b1, p, 6'b0, v.tag[23:16], 3'b0, v.tag[12], tsz, 8'b0};
    sh_epn[e] = {v.epn[31:12], 5'b0, v.epn[6:0]};
    sh_lo[e]  = {v.lo[31:12], 6'b0, v.lo[5:0]};
    sh_hi[e]  = v.hi;
  endtask

  task automatic read_check(input logic arr, input logic [1:0] way, input string req);
    logic [31:0] d;
    int e;
    e = int'(arr) * 4 + int'(way);
    reg_wr(3'd0, {23'b0, way, 3'b0, arr, 4'b0});
    run_cmd(1'b1);
    reg_rd(3'd0, d); chk({req, " R8 select"}, d, {12'b0, 4'(nv_exp), 4'b0, 2'b0, way, 3'b0, arr, 4'b0});
    reg_rd(3'd1, d); chk({req, " R3 R7 R8 tag"}, d, sh_tag[e]);
    reg_rd(3'd2, d); chk({req, " R7 page"}, d, sh_epn[e]);
    reg_rd(3'd3, d); chk({req, " R4 R6 real-low"}, d, sh_lo[e]);
    reg_rd(3'd4, d); chk({req, " R4 real-high"}, d, sh_hi[e]);
  endtask

  task automatic do_write(input vec_t v);
    reg_wr(3'd0, {23'b0, v.way, 3'b0, v.arr, 2'b0, v.qual});
    reg_wr(3'd1, v.tag);
    reg_wr(3'd2, v.epn);
    reg_wr(3'd3, v.lo);
    reg_wr(3'd4, v.hi);
    run_cmd(1'b0);
    if (v.qual == 2'd0) begin
      expect_of(v);
      nv_exp = (nv_exp + 1) % 4;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int e = 0; e < 8; e++) begin
      sh_tag[e] = 32'h8000_0000; sh_epn[e] = '0; sh_lo[e] = '0; sh_hi[e] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), d); chk("R1 staging word", d, 32'd0);
    end
    chk("R1 busy/done", {30'b0, busy, done}, 32'd0);
    read_check(1'b1, 2'd3, "R1 unwritten entry");

    // R2: register interface
    reg_wr(3'd3, 32'hCAFE_F00D);
    reg_rd(3'd3, d); chk("R2 word write", d, 32'hCAFE_F00D);
    reg_wr(3'd5, 32'h1234_5678);
    reg_rd(3'd5, d); chk("R2 index 5 reads 0", d, 32'd0);
    reg_rd(3'd3, d); chk("R2 index 5 write no effect", d, 32'hCAFE_F00D);

    // vector table: write, then read back (R3-R9, R5 drops)
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i]);
      read_check(VEC[i].arr, VEC[i].way, $sformatf("vec%0d", i));
    end

    // R11: all entries independent
    for (int e = 0; e < 8; e++) begin
      read_check(e[2], e[1:0], $sformatf("R11 entry%0d", e));
    end

    // R10: command and register write during busy are ignored
    reg_wr(3'd0, 32'h0000_0300);
    reg_wr(3'd1, 32'h0099_0200);
    reg_wr(3'd2, 32'h0000_0000);
    reg_wr(3'd3, 32'h0000_0001);
    reg_wr(3'd4, 32'h0000_0000);
    @(negedge clk);
    cmd_write = 1'b1;
    @(negedge clk);
    cmd_write = 1'b0; cmd_read = 1'b1;
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'hFFFF_FFFF;
    chk("R10 busy during ignored request", {31'b0, busy}, 32'd1);
    @(negedge clk);
    cmd_read = 1'b0; reg_we = 1'b0;
    chk("R10 done after write", {30'b0, busy, done}, 32'd1);
    @(negedge clk);
    chk("R10 request during busy ignored", {30'b0, busy, done}, 32'd0);
    reg_rd(3'd1, d); chk("R10 register write during busy ignored", d, 32'h0099_0200);
    expect_of('{1'b0, 2'd3, 2'd0, 32'h0099_0200, 32'h0, 32'h1, 32'h0});
    nv_exp = (nv_exp + 1) % 4;
    read_check(1'b0, 2'd3, "R10 R9 after busy test");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule